// File: doc/BRIEF.md
# Parallel EEPROM bus timing controller

The block sits between a simple internal request port and an asynchronous byte-wide parallel EEPROM. A single-cycle request carries a write flag, an address and, for a write, a byte. The controller then drives the active-low chip enable, output enable and write enable strobes and the bidirectional data bus so that every access time, pulse width, setup and hold window of the device is met. Each window is a parameter in nanoseconds. It is rounded up to whole cycles of the system clock, and the longest of the windows that overlap sets the wait.

A read holds chip enable and output enable low for the access time, registers the bus, releases both strobes together and then waits out the output float time before it reports ready. A write is write-enable controlled: the address and data are driven and chip enable falls, write enable follows one cycle later and rises before chip enable does. The controller then polls the device with reads of the same address until internal programming ends. A parameter selects the polling method: bit 7 matching the written data, or bit 6 no longer changing between two consecutive reads. Polling is bounded by a cycle limit. If the limit runs out, a sticky error flag is set and the controller goes back to idle.

Top module: `eeprom_ctl`

## Requirements
- R1: After reset, ready is 1, err is 0, and ce_n, oe_n and we_n are all 1. While ready is 1 no strobe is low and the bus is not driven.
- R2: A read holds ce_n and oe_n low for max(address, enable and output-enable access times) cycles and registers the bus into rdata at the edge that releases both strobes. With the defaults at 10 ns that is 12 cycles, and ready stays low for 12 + 5 = 17 cycles counted from the accepting edge.
- R3: After oe_n rises, ce_n does not fall again for at least the float time (5 cycles by default), and the controller never drives the bus while oe_n is low.
- R4: In a write, ce_n is low before we_n falls and is still low when we_n rises. we_n and oe_n are never low together.
- R5: we_n stays low for max(pulse width, data setup, address hold) cycles (10 by default). Address and data stay unchanged from the start of the write until after we_n rises.
- R6: With data polling (TOGGLE_POLL = 0), ready returns after a write only once a poll read shows bit 7 equal to the written bit 7.
- R7: With toggle polling (TOGGLE_POLL = 1), ready returns after a write only once two consecutive poll reads show the same bit 6.
- R8: If polling lasts POLL_LIMIT cycles without completing, err becomes 1, ready returns, and err stays 1 until reset.
- R9: A request seen while ready is 0 is ignored: it starts no access and changes no address, data or stored byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, taken only while ready is 1 |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Byte address |
| wdata | input | 8 | Byte to write |
| ready | output | 1 | Idle and able to accept a request |
| rdata | output | 8 | Byte registered by the last read |
| err | output | 1 | Sticky poll-timeout flag |
| mem_addr | output | AW | Address to the device |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq | inout | 8 | Bidirectional data bus |

## Verification
Writes are issued at addresses spread over the low and high ends of the range. The data values are chosen with bit 7 set and clear, so that a data poll that stops on the wrong bit sense finishes early or never. Each read is compared with a shadow copy, and its ready latency is measured; the device model returns corrupted data when an access window is cut short. Programming busy time is varied across zero, normal and longer than the poll limit. This separates immediate completion, normal completion and timeout in both polling modes. A request injected in the middle of an access checks that nothing reaches the device.

// File: rtl/eeprom_ctl.sv
module eeprom_ctl #(
  parameter int CLK_NS      = 10,
  parameter int T_ACC_NS    = 120,
  parameter int T_CE_NS     = 120,
  parameter int T_OE_NS     = 50,
  parameter int T_DF_NS     = 50,
  parameter int T_WP_NS     = 100,
  parameter int T_AH_NS     = 50,
  parameter int T_DS_NS     = 50,
  parameter int TOGGLE_POLL = 0,
  parameter int POLL_LIMIT  = 1000000,
  parameter int AW          = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          ready,
  output logic [7:0]    rdata,
  output logic          err,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  inout  wire  [7:0]    mem_dq
);
  localparam int C_ACC = (T_ACC_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_CE  = (T_CE_NS  + CLK_NS - 1) / CLK_NS;
  localparam int C_OE  = (T_OE_NS  + CLK_NS - 1) / CLK_NS;
  localparam int C_DF  = (T_DF_NS  + CLK_NS - 1) / CLK_NS;
  localparam int C_WP  = (T_WP_NS  + CLK_NS - 1) / CLK_NS;
  localparam int C_AH  = (T_AH_NS  + CLK_NS - 1) / CLK_NS;
  localparam int C_DS  = (T_DS_NS  + CLK_NS - 1) / CLK_NS;
  localparam int RD_M  = (C_ACC > C_CE) ? ((C_ACC > C_OE) ? C_ACC : C_OE)
                                        : ((C_CE > C_OE) ? C_CE : C_OE);
  localparam int WL_M  = (C_WP > C_AH) ? ((C_WP > C_DS) ? C_WP : C_DS)
                                       : ((C_AH > C_DS) ? C_AH : C_DS);
  localparam int RD_W  = (RD_M < 1) ? 1 : RD_M;
  localparam int WLOW  = (WL_M < 1) ? 1 : WL_M;
  localparam int DF_W  = (C_DF < 1) ? 1 : C_DF;
  localparam int CMAX  = (RD_W > WLOW) ? ((RD_W > DF_W) ? RD_W : DF_W)
                                       : ((WLOW > DF_W) ? WLOW : DF_W);
  localparam int CW    = $clog2(CMAX + 1);
  localparam int TW    = $clog2(POLL_LIMIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_RACC, S_RFLT, S_WSET, S_WLOW, S_WEND} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tmo;
  logic [7:0]   dout;
  logic         drv, pol, first, prv6, wb7, done_r;

  assign mem_dq = drv ? dout : 8'hzz;

  wire tmo_hit = tmo >= TW'(POLL_LIMIT);
  wire poll_ok = (TOGGLE_POLL != 0) ? (!first && (mem_dq[6] == prv6))
                                    : (mem_dq[7] == wb7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; tmo <= '0; dout <= '0; drv <= 1'b0;
      pol <= 1'b0; first <= 1'b0; prv6 <= 1'b0; wb7 <= 1'b0; done_r <= 1'b0;
      ready <= 1'b1; rdata <= '0; err <= 1'b0; mem_addr <= '0;
      mem_ce_n <= 1'b1; mem_oe_n <= 1'b1; mem_we_n <= 1'b1;
    end else begin
      if (st == S_IDLE) tmo <= '0;
      else if (pol && !tmo_hit) tmo <= tmo + 1'b1;
      case (st)
        S_IDLE: if (req) begin
          ready <= 1'b0;
          mem_addr <= addr;
          mem_ce_n <= 1'b0;
          pol <= 1'b0;
          done_r <= 1'b0;
          if (we) begin
            dout <= wdata; wb7 <= wdata[7]; drv <= 1'b1; st <= S_WSET;
          end else begin
            mem_oe_n <= 1'b0; cnt <= CW'(RD_W - 1); st <= S_RACC;
          end
        end
        S_RACC:
          if (cnt == '0) begin
            mem_ce_n <= 1'b1; mem_oe_n <= 1'b1;
            cnt <= CW'(DF_W - 1);
            if (pol) begin
              done_r <= poll_ok; prv6 <= mem_dq[6]; first <= 1'b0;
            end else rdata <= mem_dq;
            st <= S_RFLT;
          end else cnt <= cnt - 1'b1;
        S_RFLT:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!pol || done_r) begin
            ready <= 1'b1; pol <= 1'b0; st <= S_IDLE;
          end else if (tmo_hit) begin
            err <= 1'b1; ready <= 1'b1; pol <= 1'b0; st <= S_IDLE;
          end else begin
            mem_ce_n <= 1'b0; mem_oe_n <= 1'b0;
            cnt <= CW'(RD_W - 1); st <= S_RACC;
          end
        S_WSET: begin
          mem_we_n <= 1'b0; cnt <= CW'(WLOW - 1); st <= S_WLOW;
        end
        S_WLOW:
          if (cnt == '0) begin
            mem_we_n <= 1'b1; st <= S_WEND;
          end else cnt <= cnt - 1'b1;
        S_WEND: begin
          mem_ce_n <= 1'b1; drv <= 1'b0;
          pol <= 1'b1; first <= 1'b1; done_r <= 1'b0;
          cnt <= '0; st <= S_RFLT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_ctl_chk.sv
module eeprom_ctl_chk #(
  parameter int WLOW = 10,
  parameter int AW   = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          err,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          drv,
  input logic [AW-1:0] mem_addr
);
  logic [15:0] wcnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wcnt <= '0;
    else if (we_n) wcnt <= '0;
    else if (wcnt != 16'hffff) wcnt <= wcnt + 1'b1;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ce_n && oe_n && we_n && !drv));
  assert_no_drive_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !drv);
  assert_we_inside_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && oe_n && drv));
  assert_ce_after_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> !ce_n);
  assert_we_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (wcnt >= 16'(WLOW)));
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(mem_addr));
endmodule

bind eeprom_ctl eeprom_ctl_chk #(.WLOW(WLOW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .err(err), .ce_n(mem_ce_n),
  .oe_n(mem_oe_n), .we_n(mem_we_n), .drv(drv), .mem_addr(mem_addr));

// File: tb/sim_eeprom_ctl.sv
module sim_eeprom_model #(
  parameter int TOGGLE = 0
) (
  input  logic        clk,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic [16:0] addr,
  inout  wire  [7:0]  dq,
  input  int          busy_len,
  output logic        busy,
  output int          v_float,
  output int          v_order,
  output int          v_pulse
);
  logic [7:0] mem [16];
  logic [7:0] pdat = 8'h00;
  logic       tgl = 1'b0;
  logic       ce_q = 1'b1, oe_q = 1'b1, we_q = 1'b1;
  logic [16:0] a_q = '0;
  logic [7:0]  d_q = '0;
  int ce_c = 0, oe_c = 0, we_c = 0, a_c = 255, d_c = 0, flt_c = 255, busy_c = 0;

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'(i * 17);
    v_float = 0; v_order = 0; v_pulse = 0;
  end

  assign busy = busy_c != 0;
  wire ok = ce_c >= 12 && oe_c >= 5 && a_c >= 12;
  wire [7:0] pv = (TOGGLE != 0) ? {pdat[7], tgl, pdat[5:0]} : {~pdat[7], pdat[6:0]};
  wire [7:0] tv = busy ? pv : mem[addr[3:0]];
  assign dq = (!ce_n && !oe_n && we_n) ? (ok ? tv : ~tv) : 8'hzz;

  function automatic int sat(input int v);
    return (v < 255) ? v + 1 : v;
  endfunction

  always @(negedge clk) begin
    ce_q <= ce_n; oe_q <= oe_n; we_q <= we_n; a_q <= addr; d_q <= dq;
    ce_c <= ce_n ? 0 : sat(ce_c);
    oe_c <= oe_n ? 0 : sat(oe_c);
    we_c <= we_n ? 0 : sat(we_c);
    a_c  <= (addr != a_q) ? 1 : sat(a_c);
    d_c  <= (dq !== d_q) ? 1 : sat(d_c);
    flt_c <= !oe_n ? 0 : sat(flt_c);
    if (busy_c != 0) busy_c <= busy_c - 1;
    if (!ce_n && ce_q && flt_c < 5) v_float <= v_float + 1;
    if (!we_n && we_q && (ce_c == 0 || !oe_n)) v_order <= v_order + 1;
    if (we_n && !we_q) begin
      if (ce_n) v_order <= v_order + 1;
      if (we_c < 10 || d_c < 5 || a_c <= we_c) v_pulse <= v_pulse + 1;
      mem[addr[3:0]] <= dq;
      pdat <= dq;
      busy_c <= busy_len;
    end
    if (!oe_n && oe_q && busy_c != 0) tgl <= ~tgl;
  end
endmodule

module sim_eeprom_ctl;
  localparam int LIMIT = 400;
  localparam int RD_LAT = 12 + 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req0 = 1'b0, req1 = 1'b0, we = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0] wdata = '0;
  int busy0 = 60, busy1 = 60;
  logic rdy0, rdy1, err0, err1, bsy0, bsy1;
  logic [7:0] rd0, rd1;
  logic [16:0] ma0, ma1;
  logic ce0, oe0, we0, ce1, oe1, we1;
  wire [7:0] dq0, dq1;
  int vf0, vo0, vp0, vf1, vo1, vp1;
  int compared = 0, mismatched = 0;
  logic [7:0] shadow [16];

  always #5 clk = ~clk;

  eeprom_ctl #(.POLL_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req0), .we(we), .addr(addr), .wdata(wdata),
    .ready(rdy0), .rdata(rd0), .err(err0), .mem_addr(ma0), .mem_ce_n(ce0),
    .mem_oe_n(oe0), .mem_we_n(we0), .mem_dq(dq0));
  sim_eeprom_model #(.TOGGLE(0)) m0 (
    .clk(clk), .ce_n(ce0), .oe_n(oe0), .we_n(we0), .addr(ma0), .dq(dq0),
    .busy_len(busy0), .busy(bsy0), .v_float(vf0), .v_order(vo0), .v_pulse(vp0));

  eeprom_ctl #(.POLL_LIMIT(LIMIT), .TOGGLE_POLL(1)) u1 (
    .clk(clk), .rst_n(rst_n), .req(req1), .we(we), .addr(addr), .wdata(wdata),
    .ready(rdy1), .rdata(rd1), .err(err1), .mem_addr(ma1), .mem_ce_n(ce1),
    .mem_oe_n(oe1), .mem_we_n(we1), .mem_dq(dq1));
  sim_eeprom_model #(.TOGGLE(1)) m1 (
    .clk(clk), .ce_n(ce1), .oe_n(oe1), .we_n(we1), .addr(ma1), .dq(dq1),
    .busy_len(busy1), .busy(bsy1), .v_float(vf1), .v_order(vo1), .v_pulse(vp1));

  localparam logic [25:0] VEC [8] = '{
    {1'b1, 17'h00001, 8'hA5}, {1'b1, 17'h00012, 8'h3C},
    {1'b1, 17'h1FFF3, 8'h80}, {1'b1, 17'h00004, 8'h7F},
    {1'b0, 17'h00001, 8'h00}, {1'b0, 17'h00012, 8'h00},
    {1'b0, 17'h1FFF3, 8'h00}, {1'b0, 17'h00004, 8'h00}};

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic op(input int sel, input logic w, input logic [16:0] a,
                    input logic [7:0] d, input bit intrude, output int lat,
                    output logic bsy_at_ready);
    @(negedge clk);
    we = w; addr = a; wdata = d;
    if (sel == 0) req0 = 1'b1; else req1 = 1'b1;
    @(negedge clk);
    req0 = 1'b0; req1 = 1'b0;
    lat = 0;
    while ((sel == 0 ? rdy0 : rdy1) == 1'b0) begin
      lat++;
      if (intrude && lat == 3) begin
        we = 1'b1; addr = 17'h0000F; wdata = 8'hEE;
        if (sel == 0) req0 = 1'b1; else req1 = 1'b1;
      end else begin
        req0 = 1'b0; req1 = 1'b0;
      end
      @(negedge clk);
    end
    req0 = 1'b0; req1 = 1'b0;
    bsy_at_ready = (sel == 0) ? bsy0 : bsy1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int lat;
    logic b;
    for (int i = 0; i < 16; i++) shadow[i] = 8'(i * 17);
    repeat (3) @(negedge clk);
    chk("R1 reset ready", {rdy0, rdy1}, 2'b11);
    chk("R1 reset err", {err0, err1}, 2'b00);
    chk("R1 reset strobes", {ce0, oe0, we0, ce1, oe1, we1}, 6'b111111);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle strobes after reset", {ce0, oe0, we0}, 3'b111);

    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 8; i++) begin
        logic [25:0] v;
        v = VEC[i];
        op(s, v[25], v[24:8], v[7:0], 1'b0, lat, b);
        if (v[25]) begin
          if (s == 0) shadow[v[11:8]] = v[7:0];
          chk(s == 0 ? "R6 ready after data poll done" : "R7 ready after toggle poll done",
              {31'd0, b}, 32'd0);
        end else begin
          chk("R2 read latency", lat, RD_LAT);
          chk("R2 read data", s == 0 ? rd0 : rd1, shadow[v[11:8]]);
        end
      end
    end

    busy0 = 0; busy1 = 0;
    op(0, 1'b1, 17'h00005, 8'h01, 1'b0, lat, b);
    shadow[5] = 8'h01;
    chk("R6 zero busy completes", {30'd0, err0, b}, 32'd0);
    op(1, 1'b1, 17'h00005, 8'hC1, 1'b0, lat, b);
    chk("R7 zero busy completes", {30'd0, err1, b}, 32'd0);
    op(1, 1'b0, 17'h00005, 8'h00, 1'b0, lat, b);
    chk("R7 read after toggle write", rd1, 8'hC1);

    busy0 = 60;
    op(0, 1'b0, 17'h00001, 8'h00, 1'b1, lat, b);
    chk("R9 read with intruding request", rd0, shadow[1]);
    repeat (3) @(negedge clk);
    chk("R9 no access started", {ce0, oe0, we0, rdy0}, 4'b1111);
    op(0, 1'b0, 17'h0000F, 8'h00, 1'b0, lat, b);
    chk("R9 target byte untouched", rd0, shadow[15]);
    op(0, 1'b1, 17'h00006, 8'h9A, 1'b1, lat, b);
    shadow[6] = 8'h9A;
    op(0, 1'b0, 17'h0000F, 8'h00, 1'b0, lat, b);
    chk("R9 no write during busy", rd0, shadow[15]);

    chk("R8 no error before timeout", {31'd0, err0}, 32'd0);
    busy0 = 2000;
    op(0, 1'b1, 17'h00007, 8'h55, 1'b0, lat, b);
    shadow[7] = 8'h55;
    chk("R8 error on timeout", {31'd0, err0}, 32'd1);
    chk("R8 ready after timeout", {31'd0, rdy0}, 32'd1);
    chk("R8 timeout before device done", {31'd0, b}, 32'd1);
    while (bsy0) @(negedge clk);
    busy0 = 60;
    op(0, 1'b0, 17'h00007, 8'h00, 1'b0, lat, b);
    chk("R8 error stays set", {31'd0, err0}, 32'd1);
    chk("R2 read after timeout", rd0, 8'h55);

    chk("R3 float gap dp", vf0, 0);
    chk("R3 float gap tg", vf1, 0);
    chk("R4 strobe order dp", vo0, 0);
    chk("R4 strobe order tg", vo1, 0);
    chk("R5 write pulse dp", vp0, 0);
    chk("R5 write pulse tg", vp1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule